// File: doc/BRIEF.md
# Bit-Masked Control Register Bank

This block holds a bank of 16-bit control registers behind a plain one-cycle bus. Every write word is 32 bits wide: the low half carries the new data and the high half is a per-bit write enable for it. Software can therefore set or clear a single field, even a single bit, with one bus write, without first reading the register back. Bits whose enable is zero keep their stored value.

A bus request is one cycle of `bus_valid` with `bus_write` choosing the direction. The byte address must be word aligned, and it selects one of `NUM_REGS` registers. Any other address counts as unmapped. A read returns its data one cycle later, flagged by `bus_rvalid`. All register contents are driven out on a flat vector. A few named control taps are also decoded from them: a PHY power-up bit and a receive low-frequency-signalling enable bit, which share one register, two 2-bit sense selects, and two full-width port configuration words.

Top module: `mask_cfg_bank`

## Requirements
- R1: After a synchronous active-high reset, every register, every control tap and `bus_rdata` are zero.
- R2: On a write to a mapped register, data bit n (n in 0..15) takes `bus_wdata[n]` exactly when `bus_wdata[n+16]` is 1. All other bits of that register and of every other register are unchanged.
- R3: A write whose upper 16 bits are all zero leaves every register unchanged.
- R4: A single write with mask 0xFFFF loads a full 16-bit word, for example 0x1100 and then 0x0188 into the port configuration registers at byte offsets 0x1C (`port0_cfg`) and 0x34 (`port1_cfg`).
- R5: Byte offset 0x04 holds `pma_pwr_on` at bit 13 and `rx_lfps_en` at bit 14. A masked write of either bit leaves the other unchanged.
- R6: `sense_a_sel` is bits 1:0 at offset 0x00 and `sense_b_sel` is bits 3:2 at offset 0x08. Each takes the code 0x3 (enable) or 0x2 (disable) from one masked write, and its other bits stay unchanged.
- R7: A read of a mapped register raises `bus_rvalid` on the following cycle, with the stored 16 bits in `bus_rdata[15:0]` and zero in `bus_rdata[31:16]`.
- R8: An address is unmapped if its bits 1:0 are nonzero or if its word index (`bus_addr[7:2]`) is `NUM_REGS` or more. Writes to it change nothing, and reads of it return zero with `bus_rvalid`.
- R9: A write takes effect on the clock edge that accepts it, so the control outputs show the new value in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_valid | input | 1 | Request strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte address |
| bus_wdata | input | 32 | [31:16] bit enables, [15:0] data |
| bus_rdata | output | 32 | Read data, zero-extended |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| cfg_flat | output | NUM_REGS*16 | All registers, register i at bits [16i+15:16i] |
| sense_a_sel | output | 2 | Bits 1:0 of register 0 |
| pma_pwr_on | output | 1 | Bit 13 of register 1 |
| rx_lfps_en | output | 1 | Bit 14 of register 1 |
| sense_b_sel | output | 2 | Bits 3:2 of register 2 |
| port0_cfg | output | 16 | Register 7 |
| port1_cfg | output | 16 | Register 13 |

## Verification
The assertions assume that `bus_valid`, `bus_write`, `bus_addr` and `bus_wdata` are known and stable across each clock edge, and that only one request is presented per cycle. The write-containment property also relies on the bus being the only source of register change outside reset. The stimulus drives every input on the falling edge and holds a request for exactly one rising edge. It keeps `rst` high for several edges before the first access, so every `$past` value it uses comes from a cycle with defined inputs.

// File: rtl/mask_cfg_bank.sv
module mask_cfg_bank #(
  parameter int NUM_REGS    = 16,
  parameter int ADDR_W      = 8,
  parameter int SENSE_A_IDX = 0,
  parameter int CTRL_IDX    = 1,
  parameter int SENSE_B_IDX = 2,
  parameter int PORT0_IDX   = 7,
  parameter int PORT1_IDX   = 13,
  parameter int PWR_BIT     = 13,
  parameter int LFPS_BIT    = 14
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bus_valid,
  input  logic                   bus_write,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [31:0]            bus_wdata,
  output logic [31:0]            bus_rdata,
  output logic                   bus_rvalid,
  output logic [NUM_REGS*16-1:0] cfg_flat,
  output logic [1:0]             sense_a_sel,
  output logic                   pma_pwr_on,
  output logic                   rx_lfps_en,
  output logic [1:0]             sense_b_sel,
  output logic [15:0]            port0_cfg,
  output logic [15:0]            port1_cfg
);
  localparam int IDX_W = ADDR_W - 2;

  logic [15:0]      regs_q [NUM_REGS];
  logic [IDX_W-1:0] idx;
  logic             hit;
  logic [15:0]      wmask, wdata, rd_word;

  assign idx   = bus_addr[ADDR_W-1:2];
  assign hit   = (bus_addr[1:0] == 2'b00) && ({1'b0, idx} < (IDX_W+1)'(NUM_REGS));
  assign wmask = bus_wdata[31:16];
  assign wdata = bus_wdata[15:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= '0;
    end else if (bus_valid && bus_write && hit) begin
      for (int i = 0; i < NUM_REGS; i++)
        if (idx == IDX_W'(i))
          regs_q[i] <= (regs_q[i] & ~wmask) | (wdata & wmask);
    end
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (hit && idx == IDX_W'(i)) rd_word = regs_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_valid && !bus_write;
      if (bus_valid && !bus_write) bus_rdata <= {16'h0000, rd_word};
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
    assign cfg_flat[g*16 +: 16] = regs_q[g];
  end

  assign sense_a_sel = regs_q[SENSE_A_IDX][1:0];
  assign pma_pwr_on  = regs_q[CTRL_IDX][PWR_BIT];
  assign rx_lfps_en  = regs_q[CTRL_IDX][LFPS_BIT];
  assign sense_b_sel = regs_q[SENSE_B_IDX][3:2];
  assign port0_cfg   = regs_q[PORT0_IDX];
  assign port1_cfg   = regs_q[PORT1_IDX];
endmodule

// File: rtl/mask_cfg_bank_chk.sv
module mask_cfg_bank_chk #(
  parameter int NUM_REGS = 16,
  parameter int ADDR_W   = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   bus_valid,
  input logic                   bus_write,
  input logic [ADDR_W-1:0]      bus_addr,
  input logic [31:0]            bus_wdata,
  input logic [31:0]            bus_rdata,
  input logic                   bus_rvalid,
  input logic [NUM_REGS*16-1:0] cfg_flat,
  input logic                   pma_pwr_on,
  input logic                   rx_lfps_en
);
  localparam int FW    = NUM_REGS * 16;
  localparam int IDX_W = ADDR_W - 2;

  logic             mapped, wr_hit, wr_miss;
  logic [IDX_W-1:0] cidx;
  logic [FW-1:0]    allowed, spread;

  assign cidx    = bus_addr[ADDR_W-1:2];
  assign mapped  = (bus_addr[1:0] == 2'b00) && ({1'b0, cidx} < (IDX_W+1)'(NUM_REGS));
  assign wr_hit  = bus_valid && bus_write && mapped;
  assign wr_miss = bus_valid && bus_write && !mapped;
  assign allowed = wr_hit ? (FW'(bus_wdata[31:16]) << {cidx, 4'b0000}) : '0;
  assign spread  = FW'(bus_wdata[15:0]) << {cidx, 4'b0000};

  p_contain_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((cfg_flat ^ $past(cfg_flat)) & ~$past(allowed)) == '0);

  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> (cfg_flat & $past(allowed)) == ($past(spread) & $past(allowed)));

  p_zero_mask_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_write && bus_wdata[31:16] == 16'h0) |=> $stable(cfg_flat));

  p_shared_bits_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && bus_addr == ADDR_W'(4) && bus_wdata[30:29] == 2'b01) |=> $stable(rx_lfps_en));

  p_rvalid_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write) |=> bus_rvalid);

  p_rd_upper_r7: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid |-> bus_rdata[31:16] == 16'h0);

  p_unmapped_wr_r8: assert property (@(posedge clk) disable iff (rst)
    wr_miss |=> $stable(cfg_flat));

  p_unmapped_rd_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write && !mapped) |=> bus_rdata == 32'h0);

  p_power_bit_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && bus_addr == ADDR_W'(4) && bus_wdata[29]) |=> pma_pwr_on == $past(bus_wdata[13]));
endmodule

bind mask_cfg_bank mask_cfg_bank_chk #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .bus_rvalid(bus_rvalid), .cfg_flat(cfg_flat), .pma_pwr_on(pma_pwr_on),
  .rx_lfps_en(rx_lfps_en)
);

// File: tb/mask_cfg_bank_test.sv
module mask_cfg_bank_test;
  localparam int NR = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [NR*16-1:0] cfg_flat;
  logic [1:0]  sense_a_sel, sense_b_sel;
  logic        pma_pwr_on, rx_lfps_en;
  logic [15:0] port0_cfg, port1_cfg;

  int checks = 0, failures = 0;
  logic [15:0] model [NR];
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #4 clk = ~clk;

  mask_cfg_bank uut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .cfg_flat(cfg_flat), .sense_a_sel(sense_a_sel),
    .pma_pwr_on(pma_pwr_on), .rx_lfps_en(rx_lfps_en), .sense_b_sel(sense_b_sel),
    .port0_cfg(port0_cfg), .port1_cfg(port1_cfg)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] w);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = w;
    if (a[1:0] == 2'b00 && a[7:2] < NR)
      model[a[7:2]] = (model[a[7:2]] & ~w[31:16]) | (w[15:0] & w[31:16]);
    @(posedge clk);
    #1 bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, string req);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_wdata = '0;
    exp_q.push_back((a[1:0] == 2'b00 && a[7:2] < NR) ? {16'h0, model[a[7:2]]} : 32'h0);
    tag_q.push_back(req);
    @(posedge clk);
    #1 bus_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R7 actual=rvalid expected=no_read");
      end else begin
        string t;
        logic [31:0] e;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, bus_rdata, e);
      end
    end
  end

  function automatic logic [NR*16-1:0] model_flat();
    logic [NR*16-1:0] f;
    for (int i = 0; i < NR; i++) f[i*16 +: 16] = model[i];
    return f;
  endfunction

  task automatic check_flat(string req);
    @(negedge clk);
    checks++;
    if (cfg_flat !== model_flat()) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, cfg_flat, model_flat());
    end
  endtask

  initial begin
    #(8 * 20000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < NR; i++) model[i] = '0;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 flat", cfg_flat[31:0], 32'h0);
    check_flat("R1");
    check("R1 rdata", bus_rdata, 32'h0);
    check("R1 taps", {port0_cfg, port1_cfg}, 32'h0);
    rd(8'h1c, "R1 read");
    rd(8'h04, "R1 read ctrl");

    // R5 shared bits, R9 timing
    wr(8'h04, 32'h2000_2000);
    @(negedge clk);
    check("R9 pwr", {31'h0, pma_pwr_on}, 32'h1);
    check("R5 lfps", {31'h0, rx_lfps_en}, 32'h0);
    wr(8'h04, 32'h4000_4000);
    @(negedge clk);
    check("R5 both", {30'h0, rx_lfps_en, pma_pwr_on}, 32'h3);
    wr(8'h04, 32'h2000_4000);
    @(negedge clk);
    check("R5 clear pwr", {30'h0, rx_lfps_en, pma_pwr_on}, 32'h2);
    rd(8'h04, "R5 read");

    // R4 full word
    wr(8'h1c, 32'hFFFF_1100);
    wr(8'h34, 32'hFFFF_0188);
    @(negedge clk);
    check("R4 port0", {16'h0, port0_cfg}, 32'h1100);
    check("R4 port1", {16'h0, port1_cfg}, 32'h0188);
    wr(8'h1c, 32'hFFFF_0188);
    @(negedge clk);
    check("R4 port0 b", {16'h0, port0_cfg}, 32'h0188);
    rd(8'h34, "R4 read");

    // R6 two-bit fields
    wr(8'h00, 32'hFFFF_F0F0);
    wr(8'h00, 32'h0003_0003);
    wr(8'h08, 32'h000C_000C);
    @(negedge clk);
    check("R6 sense_a en", {30'h0, sense_a_sel}, 32'h3);
    check("R6 sense_b en", {30'h0, sense_b_sel}, 32'h3);
    wr(8'h00, 32'h0003_0002);
    wr(8'h08, 32'h000C_0008);
    @(negedge clk);
    check("R6 sense_a dis", {30'h0, sense_a_sel}, 32'h2);
    check("R6 sense_b dis", {30'h0, sense_b_sel}, 32'h2);
    rd(8'h00, "R6 read a");
    rd(8'h08, "R6 read b");

    // R2 partial masks
    wr(8'h14, 32'hFFFF_1234);
    wr(8'h14, 32'h00FF_ABCD);
    wr(8'h14, 32'hA500_FFFF);
    check_flat("R2");
    rd(8'h14, "R2 read");
    wr(8'h3c, 32'h8001_FFFF);
    rd(8'h3c, "R2 top reg");

    // R3 zero mask
    wr(8'h1c, 32'h0000_FFFF);
    @(negedge clk);
    check("R3 port0", {16'h0, port0_cfg}, 32'h0188);
    check_flat("R3");

    // R8 unmapped
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'h1d, 32'hFFFF_0000);
    wr(8'h06, 32'hFFFF_0000);
    check_flat("R8 writes");
    rd(8'h40, "R8 read idx");
    rd(8'h1d, "R8 read misaligned");
    rd(8'hfc, "R8 read top");

    // R7 back-to-back reads
    rd(8'h1c, "R7 b2b a");
    rd(8'h34, "R7 b2b b");
    @(negedge clk);
    @(negedge clk);
    check("R7 drained", exp_q.size(), 32'h0);

    // R1 reset again
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1 rst = 1'b0;
    for (int i = 0; i < NR; i++) model[i] = '0;
    check_flat("R1 rereset");
    rd(8'h34, "R1 read after reset");
    @(negedge clk);
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule